// File: doc/BRIEF.md
# Serial Packet Port Receiver

This block sits on one input port of a packet router and turns a single-bit serial stream into a destination address, a connection request and a sequence of payload bytes. An active-low frame line marks the extent of each packet. The header is fixed. Four address bits come first, least significant first. One pad bit follows, and it must be 1. Three gap cycles come after the pad, and the block ignores the data and valid lines during them. The payload follows the gap.

Once the header is accepted, the block raises a connection request toward the arbiter. A grant from the arbiter sets the busy line. After that, a payload bit is taken only on a cycle where busy_n is 1 and the bit is marked valid. Accepted bits are packed into bytes, least significant bit first. At the end of the frame, the block emits any partial byte together with its bit count and pulses a frame-done strobe.

Protocol faults raise a one-cycle error pulse and drop the packet. The faults are a pad bit of 0, the frame line rising before the payload phase, and a new frame with no idle cycle after the previous one. All outputs are registered and appear one cycle after the input cycle that caused them.

Top module: `serial_port_rx`

## Requirements
- R1: While rst_n is 0, and on the first cycle after it, every output is 0: busy_n, req, dest_addr, byte_valid, byte_bits, frame_done and proto_err.
- R2: A frame starts on a cycle with frame_n=0 when the receiver is idle and armed. That cycle and the next three carry address bits 0..3 in that order. If the fifth cycle carries din=1 with frame_n=0, dest_addr shows the address and req rises on the following cycle.
- R3: A pad bit of 0, or frame_n=1 during the address, pad or gap cycles, gives proto_err=1 for exactly one cycle on the next cycle. The packet is then dropped: req and busy_n return to 0 and no byte or frame_done follows.
- R4: busy_n rises on the cycle after one where req=1 and grant=1. It stays 1, whatever grant does, until the frame ends. It falls together with req on the cycle after the last data cycle.
- R5: The three cycles after the pad bit are a gap. valid_n and din are ignored there, and the payload phase begins on the fourth cycle after the pad.
- R6: In the payload phase, din is accepted only on cycles with busy_n=1 and valid_n=0. Bit k of a byte is the k-th accepted bit. After every eighth accepted bit, byte_valid pulses for one cycle with byte_bits=8.
- R7: The payload phase ends on the cycle where frame_n=1, and that cycle's bit is still accepted if it qualifies. frame_done pulses on the next cycle. If 1 to 7 bits are pending, they appear in the same cycle with byte_valid=1, byte_bits set to their count, and the unused upper bits at 0.
- R8: If frame_n=0 on the first cycle after a frame's last data cycle, proto_err pulses on the next cycle and no frame starts until frame_n has been 1.
- R9: After a dropped packet, a frame_n held at 0 starts no frame. The receiver rearms only after a cycle with frame_n=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_n | input | 1 | Frame envelope, active low |
| valid_n | input | 1 | Payload bit qualifier, active low |
| din | input | 1 | Serial data line |
| grant | input | 1 | Connection grant from the arbiter |
| busy_n | output | 1 | 1 while a connection is held and payload may flow |
| req | output | 1 | Connection request, held from header accept to frame end |
| dest_addr | output | ADDR_W | Decoded destination address |
| byte_data | output | BYTE_W | Assembled payload byte, valid with byte_valid |
| byte_valid | output | 1 | One-cycle byte strobe |
| byte_bits | output | clog2(BYTE_W+1) | Number of valid bits in byte_data |
| frame_done | output | 1 | One-cycle end-of-frame strobe |
| proto_err | output | 1 | One-cycle protocol error pulse |

## Verification
The assertions assume that grant is a level the arbiter can drop at any time, and that frame_n, valid_n and din change only between clock edges. They rely on nothing else about the sender, because every protocol violation the sender can make is itself a requirement. The stimulus makes its choices from the bench model's own view of busy. It offers valid bits before the grant arrives and during the gap to show they are ignored, stalls valid mid-payload, and commits the last bit only together with the rising frame line. Deliberate faults come in short directed bursts: a zero pad, a frame rise in the gap or the address, and back-to-back frames.

// File: rtl/sprx_pkg.sv
package sprx_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_PAD,
    PH_GAP,
    PH_DATA
  } phase_e;
endpackage

// File: rtl/sprx_framer.sv
module sprx_framer
  import sprx_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int GAP_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              din,
  output logic [ADDR_W-1:0] addr,
  output logic              hdr_ok,
  output logic              frame_end,
  output logic              in_data,
  output logic              abort,
  output logic              err
);
  localparam int MAXC = (ADDR_W > GAP_CYC) ? ADDR_W : GAP_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  phase_e            st;
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] sh;
  logic              armed;
  logic              chk;
  logic              gap_err;

  always_comb begin
    abort     = ((st == PH_ADDR || st == PH_GAP) && frame_n) ||
                (st == PH_PAD && (frame_n || !din));
    hdr_ok    = (st == PH_PAD) && !abort;
    frame_end = (st == PH_DATA) && frame_n;
    in_data   = (st == PH_DATA);
    gap_err   = (st == PH_IDLE) && !armed && chk && !frame_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= PH_IDLE;
      cnt   <= '0;
      sh    <= '0;
      addr  <= '0;
      armed <= 1'b1;
      chk   <= 1'b0;
      err   <= 1'b0;
    end else begin
      err <= abort | gap_err;
      if (abort) begin
        st    <= PH_IDLE;
        armed <= frame_n;
        chk   <= 1'b0;
      end else begin
        case (st)
          PH_IDLE: begin
            if (!armed) begin
              armed <= frame_n;
              chk   <= 1'b0;
            end else if (!frame_n) begin
              sh  <= {din, sh[ADDR_W-1:1]};
              cnt <= CW'(1);
              st  <= PH_ADDR;
            end
          end
          PH_ADDR: begin
            sh  <= {din, sh[ADDR_W-1:1]};
            cnt <= cnt + CW'(1);
            if (cnt == CW'(ADDR_W - 1)) st <= PH_PAD;
          end
          PH_PAD: begin
            addr <= sh;
            cnt  <= '0;
            st   <= PH_GAP;
          end
          PH_GAP: begin
            cnt <= cnt + CW'(1);
            if (cnt == CW'(GAP_CYC - 1)) st <= PH_DATA;
          end
          PH_DATA: begin
            if (frame_n) begin
              st    <= PH_IDLE;
              armed <= 1'b0;
              chk   <= 1'b1;
            end
          end
          default: st <= PH_IDLE;
        endcase
      end
    end
  end

  assert_err_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);
  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st != PH_PAD) |=> $stable(addr));
endmodule

// File: rtl/sprx_link.sv
module sprx_link (
  input  logic clk,
  input  logic rst_n,
  input  logic hdr_ok,
  input  logic clr,
  input  logic grant,
  output logic req,
  output logic busy_n
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req    <= 1'b0;
      busy_n <= 1'b0;
    end else if (clr) begin
      req    <= 1'b0;
      busy_n <= 1'b0;
    end else begin
      if (hdr_ok) req <= 1'b1;
      if (req && grant) busy_n <= 1'b1;
    end
  end

  assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_n && !clr) |=> busy_n);
  assert_busy_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_n |-> req);
endmodule

// File: rtl/sprx_packer.sv
module sprx_packer #(
  parameter int BYTE_W = 8,
  localparam int CW    = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_data,
  input  logic              valid_n,
  input  logic              busy_n,
  input  logic              din,
  input  logic              frame_end,
  output logic [BYTE_W-1:0] data,
  output logic              vld,
  output logic [CW-1:0]     bits,
  output logic              eof
);
  localparam int IW = $clog2(BYTE_W);

  logic [BYTE_W-1:0] acc_q, acc_n;
  logic [CW-1:0]     n_q, n_n;
  logic              take, flush;

  always_comb begin
    take  = in_data && !valid_n && busy_n;
    acc_n = acc_q;
    n_n   = n_q;
    if (take) begin
      acc_n[n_q[IW-1:0]] = din;
      n_n = n_q + CW'(1);
    end
    flush = (n_n == CW'(BYTE_W)) || (frame_end && (n_n != '0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      n_q   <= '0;
      data  <= '0;
      bits  <= '0;
      vld   <= 1'b0;
      eof   <= 1'b0;
    end else begin
      vld <= flush;
      eof <= frame_end;
      if (flush) begin
        data  <= acc_n;
        bits  <= n_n;
        acc_q <= '0;
        n_q   <= '0;
      end else begin
        acc_q <= acc_n;
        n_q   <= n_n;
      end
    end
  end

  assert_bits_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> (bits != '0 && bits <= CW'(BYTE_W)));
  assert_full_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !eof) |-> (bits == CW'(BYTE_W)));
  assert_eof_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eof |=> !eof);
endmodule

// File: rtl/serial_port_rx.sv
module serial_port_rx #(
  parameter int ADDR_W  = 4,
  parameter int GAP_CYC = 3,
  parameter int BYTE_W  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         frame_n,
  input  logic                         valid_n,
  input  logic                         din,
  input  logic                         grant,
  output logic                         busy_n,
  output logic                         req,
  output logic [ADDR_W-1:0]            dest_addr,
  output logic [BYTE_W-1:0]            byte_data,
  output logic                         byte_valid,
  output logic [$clog2(BYTE_W+1)-1:0]  byte_bits,
  output logic                         frame_done,
  output logic                         proto_err
);
  logic hdr_ok, frame_end, in_data, abort;

  sprx_framer #(.ADDR_W(ADDR_W), .GAP_CYC(GAP_CYC)) u_framer (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .din(din),
    .addr(dest_addr), .hdr_ok(hdr_ok), .frame_end(frame_end),
    .in_data(in_data), .abort(abort), .err(proto_err)
  );

  sprx_link u_link (
    .clk(clk), .rst_n(rst_n), .hdr_ok(hdr_ok), .clr(frame_end | abort),
    .grant(grant), .req(req), .busy_n(busy_n)
  );

  sprx_packer #(.BYTE_W(BYTE_W)) u_packer (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .valid_n(valid_n),
    .busy_n(busy_n), .din(din), .frame_end(frame_end),
    .data(byte_data), .vld(byte_valid), .bits(byte_bits), .eof(frame_done)
  );

  assert_no_err_while_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_n |-> !proto_err);
endmodule

// File: tb/serial_port_rx_test.sv
`timescale 1ns/1ps
module serial_port_rx_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1, valid_n = 1'b1, din = 1'b0, grant = 1'b0;
  logic       busy_n, req, byte_valid, frame_done, proto_err;
  logic [3:0] dest_addr;
  logic [7:0] byte_data;
  logic [3:0] byte_bits;

  int tests = 0, fails = 0;
  bit done = 0;

  serial_port_rx uut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .valid_n(valid_n), .din(din),
    .grant(grant), .busy_n(busy_n), .req(req), .dest_addr(dest_addr),
    .byte_data(byte_data), .byte_valid(byte_valid), .byte_bits(byte_bits),
    .frame_done(frame_done), .proto_err(proto_err)
  );

  always #2 clk = ~clk;

  // reference model state
  int   ph = 0, k = 0;
  bit   armed = 1, chkgap = 0;
  bit   aq[$];
  bit   pq[$];
  logic [3:0] e_addr = 0;
  logic [7:0] e_data = 0;
  int   e_bits = 0;
  bit   e_req = 0, e_busy = 0, e_err = 0, e_vld = 0, e_eof = 0;

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit fr, bit vl, bit d, bit g);
    bit ob = e_busy, oreq = e_req, ab = 0, fin = 0, hdr = 0;
    e_err = 0; e_vld = 0; e_eof = 0;
    case (ph)
      0: if (!armed) begin
           if (!fr && chkgap) e_err = 1;
           armed = fr; chkgap = 0;
         end else if (!fr) begin
           aq.delete(); aq.push_back(d); ph = 1;
         end
      1: if (fr) ab = 1;
         else begin aq.push_back(d); if (aq.size() == 4) ph = 2; end
      2: if (fr || !d) ab = 1;
         else begin
           hdr = 1; e_addr = {aq[3], aq[2], aq[1], aq[0]}; ph = 3; k = 0;
         end
      3: if (fr) ab = 1;
         else begin k++; if (k == 3) ph = 4; end
      default: begin
        if (!vl && ob) pq.push_back(d);
        if (pq.size() == 8 || (fr && pq.size() > 0)) begin
          e_data = 0;
          foreach (pq[i]) e_data[i] = pq[i];
          e_bits = pq.size(); e_vld = 1; pq.delete();
        end
        if (fr) begin fin = 1; e_eof = 1; ph = 0; armed = 0; chkgap = 1; end
      end
    endcase
    if (ab) begin e_err = 1; ph = 0; armed = fr; chkgap = 0; end
    if (ab || fin) begin e_req = 0; e_busy = 0; end
    else begin
      if (hdr) e_req = 1;
      if (oreq && g) e_busy = 1;
    end
  endtask

  task automatic compare();
    check("R3 R8 R9 proto_err", proto_err, e_err);
    check("R6 R5 byte_valid", byte_valid, e_vld);
    if (e_vld) begin
      check(e_eof ? "R7 byte_data" : "R6 byte_data", byte_data, e_data);
      check(e_eof ? "R7 byte_bits" : "R6 byte_bits", byte_bits, e_bits);
    end
    check("R7 frame_done", frame_done, e_eof);
    check("R4 busy_n", busy_n, e_busy);
    check("R2 req", req, e_req);
    if (e_req) check("R2 dest_addr", dest_addr, e_addr);
  endtask

  task automatic tick(bit fr, bit vl, bit d, bit g);
    frame_n = fr; valid_n = vl; din = d; grant = g;
    @(posedge clk);
    step(fr, vl, d, g);
    @(negedge clk);
    compare();
  endtask

  // one packet; gd = data cycles before grant, stall = periodic valid gaps
  task automatic pkt(logic [3:0] a, int nb, logic [15:0] pl, int gd, bit stall, bit b2b);
    int cyc = 0, i = 0;
    for (int b = 0; b < 4; b++) tick(0, 1, a[b], 0);
    tick(0, 1, 1, 0);
    for (int b = 0; b < 3; b++) tick(0, 0, 1, gd == 0);   // R5 gap: valid_n low ignored
    while (i < nb && cyc < 300) begin
      bit g = (cyc >= gd);
      bit v = e_busy && !(stall && (cyc % 3 == 2));
      bit last = v && (i == nb - 1);
      tick(last, e_busy ? !v : 1'b0, v ? pl[i] : 1'b1, g);   // R6: offered bits ignored while busy_n=0
      if (v) i++;
      cyc++;
    end
    if (!b2b) tick(1, 1, 0, 0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 3; c++) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 busy_n", busy_n, 0);
    check("R1 req", req, 0);
    check("R1 dest_addr", dest_addr, 0);
    check("R1 byte_valid", byte_valid, 0);
    check("R1 byte_bits", byte_bits, 0);
    check("R1 frame_done", frame_done, 0);
    check("R1 proto_err", proto_err, 0);
    rst_n = 1'b1;
    tick(1, 1, 0, 0);
    check("R1 after release", {busy_n, req, proto_err, frame_done}, 0);

    pkt(4'hA, 10, 16'h02D5, 0, 0, 0);        // R2 R6 R7 partial of 2 bits
    pkt(4'h3, 8, 16'h00A5, 2, 1, 0);         // R4 late grant, R7 exact byte at end
    pkt(4'hF, 5, 16'h0013, 1, 1, 0);         // R7 partial of 5
    pkt(4'h9, 16, 16'hC3E1, 0, 1, 0);        // R6 two full bytes

    // R3 pad bit 0, then R9 frame held low without restart
    tick(0, 1, 0, 0); tick(0, 1, 1, 0); tick(0, 1, 1, 0); tick(0, 1, 0, 0);
    tick(0, 1, 0, 1);
    for (int c = 0; c < 3; c++) tick(0, 1, 1, 1);
    tick(1, 1, 0, 0);
    pkt(4'h5, 3, 16'h0005, 0, 0, 0);

    // R3 frame rises during gap after req is up
    tick(0, 1, 1, 0); tick(0, 1, 0, 0); tick(0, 1, 0, 0); tick(0, 1, 1, 0);
    tick(0, 1, 1, 1); tick(0, 1, 1, 1); tick(1, 1, 0, 1); tick(1, 1, 0, 0);

    // R3 frame rises during address
    tick(0, 1, 1, 0); tick(1, 1, 0, 0); tick(1, 1, 0, 0);

    // R8 back-to-back frame without idle cycle
    pkt(4'h6, 4, 16'h000B, 0, 0, 1);
    tick(0, 1, 1, 0);
    tick(0, 1, 0, 0); tick(0, 1, 1, 0);
    tick(1, 1, 0, 0);
    pkt(4'hC, 9, 16'h01FF, 3, 0, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule